// File: doc/BRIEF.md
# Flash Block Protection Manager

This block keeps the write-protection state of every erasable block of a flash array and decides whether a program or erase request may proceed. Each block has two protection levels. The ordinary lock can be set and cleared at will. The lock-down level is stronger and can only be left through reset. Every block comes out of power-up or reset locked.

Protection commands (lock, unlock, lock-down) arrive with a block index. A check request carries the index of the block that a program or erase operation wants to touch. The answer comes back in the same cycle. A command that hits the same block in the same cycle is already taken into account, so changes have no latency. A denied request sets a sticky protection-error flag, which stays set until it is cleared. A separate read port returns the protection code of any block. Command decoding from a bus and the program/erase engine are outside this block.

Top module: `flash_blk_guard`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every in-range block reads back as locked (01) and `err_flag` is 0.
- R2: `rd_state` gives the current state of block `rd_blk` combinationally: 00 means unlocked, 01 means locked and 11 means locked-down. The code 10 never appears.
- R3: The command `cmd_op`=01 (lock) makes an unlocked or locked block locked from the next clock edge. It leaves a locked-down block at 11.
- R4: The command `cmd_op`=10 (unlock) makes a locked block unlocked (00) from the next clock edge.
- R5: The command `cmd_op`=11 (lock-down) makes any block locked-down (11) from the next clock edge.
- R6: A locked-down block ignores unlock commands. Only reset clears lock-down, and the block is then locked (01).
- R7: `req_ok` is 1 only when `req_valid` is 1 and the addressed block is unlocked. Otherwise it is 0.
- R8: When a valid command hits the requested block in the same cycle, `req_ok` is judged on the state that the command produces. When the command hits a different block, `req_ok` is judged on the requested block's current state.
- R9: A command changes only the addressed block, and `cmd_op`=00 changes nothing.
- R10: `err_flag` becomes 1 at the clock edge that follows a cycle with `req_valid`=1 and `req_ok`=0. It then holds until `err_clr` is 1 in a cycle without such a denial. A denial in the same cycle as a clear wins, and the flag stays set.
- R11: A block index of `NUM_BLOCKS` or above refers to no block. A command with such an index has no effect, a request is denied, and `rd_state` returns 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cmd_valid | input | 1 | A protection command is present |
| cmd_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmd_blk | input | IDX_W | Block index of the command |
| req_valid | input | 1 | A program/erase check request is present |
| req_blk | input | IDX_W | Block index of the request |
| req_ok | output | 1 | The request is allowed (combinational) |
| err_clr | input | 1 | Clears the protection-error flag |
| err_flag | output | 1 | Sticky protection-error flag |
| rd_blk | input | IDX_W | Block index for read-back |
| rd_state | output | 2 | Protection code of block `rd_blk` |

## Verification
Two things can fall in the same cycle: a protection command and a check request on the same block, and a denial together with an error clear. The bench sweeps every block from each starting state (unlocked, locked, locked-down). For each one it applies all four command codes together with a request, once on the same block and once on a neighbouring block. The bench keeps its own table of block states and compares each `req_ok` with the state that the command should produce or leave alone. Separate cycles drive a denial and `err_clr` together and check that the flag survives. A clear without a denial must drop the flag.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOCK   = 2'b01,
    OP_UNLOCK = 2'b10,
    OP_DOWN   = 2'b11
  } fbg_op_e;

  typedef enum logic [1:0] {
    ST_OPEN   = 2'b00,
    ST_LOCKED = 2'b01,
    ST_DOWN   = 2'b11
  } fbg_state_e;

  // State after one command; {down, lock} bit order.
  function automatic logic [1:0] fbg_apply(input logic [1:0] cur, input logic [1:0] op);
    logic [1:0] res;
    case (op)
      OP_LOCK:   res = {cur[1], 1'b1};
      OP_UNLOCK: res = cur[1] ? cur : ST_OPEN;
      OP_DOWN:   res = ST_DOWN;
      default:   res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/fbg_cmd_decode.sv
module fbg_cmd_decode #(
  parameter int NUM_BLOCKS = 71,
  parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid_i,
  input  logic [IDX_W-1:0]      cmd_blk_i,
  output logic [NUM_BLOCKS-1:0] hit_o
);

  genvar g;
  generate
    for (g = 0; g < NUM_BLOCKS; g++) begin : g_hit
      assign hit_o[g] = cmd_valid_i && (cmd_blk_i == IDX_W'(g));
    end
  endgenerate

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o)); // R9

endmodule

// File: rtl/fbg_block_cell.sv
module fbg_block_cell
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_i,
  input  logic [1:0] op_i,
  output logic [1:0] state_o
);

  logic lock_q, down_q;
  logic lock_d, down_d;
  logic [1:0] nxt;
  logic       en;

  assign en = hit_i && (op_i != OP_NONE);

  always_comb begin
    nxt    = fbg_apply({down_q, lock_q}, op_i);
    lock_d = lock_q;
    down_d = down_q;
    if (en) begin
      lock_d = nxt[0];
      down_d = nxt[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      down_q <= 1'b0;
    end else if (en) begin
      lock_q <= lock_d;
      down_q <= down_d;
    end
  end

  assign state_o = {down_q, lock_q};

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b10); // R2
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    down_q |=> down_q && lock_q); // R6
  AST_LOCK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && op_i == OP_LOCK |=> lock_q); // R3
  AST_UNLOCK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && op_i == OP_UNLOCK && !down_q |=> !lock_q); // R4
  AST_DOWN_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i && op_i == OP_DOWN |=> down_q && lock_q); // R5
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> $stable(state_o)); // R9

endmodule

// File: rtl/fbg_req_check.sv
module fbg_req_check
  import fbg_pkg::*;
#(
  parameter int NUM_BLOCKS = 71,
  parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*NUM_BLOCKS-1:0] state_i,
  input  logic                    cmd_valid_i,
  input  logic [1:0]              cmd_op_i,
  input  logic [IDX_W-1:0]        cmd_blk_i,
  input  logic                    req_valid_i,
  input  logic [IDX_W-1:0]        req_blk_i,
  output logic                    ok_o,
  output logic                    deny_o
);

  logic [1:0] cur, eff;
  logic       in_range;
  logic       same_blk;

  always_comb begin
    cur      = ST_LOCKED;
    in_range = 1'b0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (req_blk_i == IDX_W'(i)) begin
        cur      = state_i[2*i +: 2];
        in_range = 1'b1;
      end
    end
  end

  assign same_blk = cmd_valid_i && (cmd_blk_i == req_blk_i);
  assign eff      = same_blk ? fbg_apply(cur, cmd_op_i) : cur;
  assign ok_o     = req_valid_i && in_range && (eff == ST_OPEN);
  assign deny_o   = req_valid_i && !ok_o;

  AST_NO_GRANT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && in_range && cur[1] |-> !ok_o); // R7

endmodule

// File: rtl/fbg_err_flag.sv
module fbg_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic deny_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, en;

  assign en = deny_i || clr_i;

  always_comb begin
    flag_d = flag_q;
    if (deny_i)     flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag_q <= 1'b0;
    else if (en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    deny_i |=> flag_o); // R10
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o && !deny_i |=> !flag_o); // R10

endmodule

// File: rtl/flash_blk_guard.sv
module flash_blk_guard
  import fbg_pkg::*;
#(
  parameter int NUM_BLOCKS = 71,
  parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_blk,
  output logic             req_ok,
  input  logic             err_clr,
  output logic             err_flag,
  input  logic [IDX_W-1:0] rd_blk,
  output logic [1:0]       rd_state
);

  localparam int STATE_W = 2 * NUM_BLOCKS;

  logic [NUM_BLOCKS-1:0] hit;
  logic [STATE_W-1:0]    state_flat;
  logic                  deny;

  fbg_cmd_decode #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_blk_i   (cmd_blk),
    .hit_o       (hit)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_BLOCKS; g++) begin : g_cell
      fbg_block_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit[g]),
        .op_i    (cmd_op),
        .state_o (state_flat[2*g +: 2])
      );
    end
  endgenerate

  fbg_req_check #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state_flat),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_blk_i   (cmd_blk),
    .req_valid_i (req_valid),
    .req_blk_i   (req_blk),
    .ok_o        (req_ok),
    .deny_o      (deny)
  );

  fbg_err_flag u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .deny_i (deny),
    .clr_i  (err_clr),
    .flag_o (err_flag)
  );

  // Read-back mux; out-of-range indices report locked (R11).
  always_comb begin
    rd_state = ST_LOCKED;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (rd_blk == IDX_W'(i)) rd_state = state_flat[2*i +: 2];
    end
  end

  AST_RD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_state != 2'b10); // R2
  AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ok); // R7

endmodule

// File: tb/flash_blk_guard_tb.sv
`timescale 1ns/1ps
module flash_blk_guard_tb;

  localparam int NB   = 12;
  localparam int IW   = 4;
  localparam int NIDX = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, req_valid, err_clr;
  logic [1:0]    cmd_op;
  logic [IW-1:0] cmd_blk, req_blk, rd_blk;
  logic          req_ok, err_flag;
  logic [1:0]    rd_state;

  int errors = 0;
  int checks = 0;

  logic [1:0] model [NIDX];
  logic       err_m;

  always #2 clk = ~clk;

  flash_blk_guard #(.NUM_BLOCKS(NB), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .req_valid(req_valid), .req_blk(req_blk), .req_ok(req_ok),
    .err_clr(err_clr), .err_flag(err_flag),
    .rd_blk(rd_blk), .rd_state(rd_state)
  );

  function automatic logic [1:0] next_code(input logic [1:0] cur, input logic [1:0] op);
    if (op == 2'b11) return 2'b11;
    if (cur == 2'b11) return 2'b11;
    if (op == 2'b01) return 2'b01;
    if (op == 2'b10) return 2'b00;
    return cur;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 0; req_valid = 0; err_clr = 0;
    cmd_op = 0; cmd_blk = 0; req_blk = 0; rd_blk = 0;
    for (int b = 0; b < NIDX; b++) model[b] = 2'b01;
    err_m = 1'b0;
    #1;
    check("R1 flag in reset", {1'b0, err_flag}, 2'b00);
    check("R1 state in reset", rd_state, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic cv, input logic [1:0] op, input logic [IW-1:0] cb,
                      input logic rv, input logic [IW-1:0] rb, input logic clr,
                      input string req);
    logic [1:0] eff;
    logic       exp_ok;
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_blk = cb;
    req_valid = rv; req_blk = rb; err_clr = clr;
    #1;
    eff = model[rb];
    if (cv && cb == rb) eff = next_code(eff, op);
    exp_ok = rv && (int'(rb) < NB) && (eff == 2'b00);
    check(req, {1'b0, req_ok}, {1'b0, exp_ok});
    @(posedge clk);
    #1;
    if (cv && int'(cb) < NB) model[cb] = next_code(model[cb], op);
    if (rv && !exp_ok) err_m = 1'b1;
    else if (clr) err_m = 1'b0;
    check({req, " R10 flag"}, {1'b0, err_flag}, {1'b0, err_m});
    cmd_valid = 0; req_valid = 0; err_clr = 0;
  endtask

  task automatic check_all(input string req);
    for (int b = 0; b < NIDX; b++) begin
      rd_blk = IW'(b);
      #0.2;
      check(req, rd_state, (b < NB) ? model[b] : 2'b01);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    do_reset();
    @(negedge clk);
    check_all("R1 R11 reset read-back");

    // R7: every block denied while locked; R10 flag set then cleared
    for (int b = 0; b < NIDX; b++) step(0, 2'b00, 0, 1, IW'(b), 0, "R7 locked deny");
    step(0, 2'b00, 0, 0, 0, 0, "R10 hold");
    step(0, 2'b00, 0, 0, 0, 1, "R10 clear");

    // R4/R9: unlock even blocks only
    for (int b = 0; b < NIDX; b += 2) step(1, 2'b10, IW'(b), 0, 0, 0, "R4 unlock");
    @(negedge clk);
    check_all("R4 R9 R11 after unlock");
    for (int b = 0; b < NIDX; b++) step(0, 2'b00, 0, 1, IW'(b), 0, "R7 R11 grant map");
    step(0, 2'b00, 0, 0, 0, 1, "R10 clear");

    // R5/R6/R3: lock-down then attempts to open
    step(1, 2'b11, 4'd3, 0, 0, 0, "R5 down from locked");
    step(1, 2'b11, 4'd4, 0, 0, 0, "R5 down from open");
    step(1, 2'b10, 4'd3, 1, 4'd3, 0, "R6 unlock ignored");
    step(1, 2'b10, 4'd4, 0, 0, 0, "R6 unlock ignored");
    step(1, 2'b01, 4'd4, 0, 0, 1, "R3 lock keeps down");
    step(1, 2'b00, 4'd6, 0, 0, 0, "R9 no-op");
    @(negedge clk);
    check_all("R3 R6 R9 codes");

    // R10: denial and clear in the same cycle, set wins
    step(0, 2'b00, 0, 1, 4'd3, 1, "R10 deny with clear");
    step(0, 2'b00, 0, 0, 0, 1, "R10 clear alone");

    // R6: reset leaves formerly locked-down blocks locked
    do_reset();
    @(negedge clk);
    check_all("R6 reset clears down");

    // R8/R3/R4/R5/R9/R11 sweep: every start state, every op, same or neighbour block
    for (int pre = 0; pre < 3; pre++) begin
      for (int op = 0; op < 4; op++) begin
        for (int nb = 0; nb < 2; nb++) begin
          do_reset();
          for (int b = 0; b < NIDX; b++) begin
            if (pre == 0) step(1, 2'b10, IW'(b), 0, 0, 0, "R4 prep");
            if (pre == 2) step(1, 2'b11, IW'(b), 0, 0, 0, "R5 prep");
          end
          for (int b = 0; b < NIDX; b++) begin
            step(1, op[1:0], IW'(b), 1, IW'((b + nb) % NIDX), 0, "R8 same-cycle");
            @(negedge clk);
            rd_blk = IW'(b);
            #0.2;
            check("R3 R4 R5 R11 after op", rd_state, (b < NB) ? model[b] : 2'b01);
            if (pre == 0) step(1, 2'b10, IW'(b), 0, 0, 1, "R4 restore");
          end
          @(negedge clk);
          check_all("R9 sweep map");
        end
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule